// File: doc/BRIEF.md
# Processor Bus Address Decoder

This block sits between an 8-bit processor and its memory-mapped neighbours. Each access carries a 16-bit address, a write flag and write data. The block registers the access and raises one chip select for the target that owns the address. The targets are an internal 2 KB work RAM, an eight-register video window, an audio/IO register page, the two serial controller ports and the cartridge port. For reads, it returns data from the selected target through one multiplexer.

The block also paces the neighbours. Each access runs the video unit for three enable cycles and the audio unit for one. A video NMI raised during those video cycles is passed to the processor, and so is an audio IRQ raised during the audio cycle.

The block keeps its own copy of the NMI-enable bit, bit 7 of video register 0. A write that sets this bit from 0 to 1 while vertical blank is active arms a delayed NMI. That NMI reaches the processor on the next access.

Top module: `cpu_bus_decode`

## Requirements
- R1: Addresses 0x0000-0x1FFF select the work RAM (cs bit 0), which is indexed by address bits [10:0], so the same byte is reached every 0x800 bytes.
- R2: Addresses 0x2000-0x3FFF select the video window (cs bit 1), and bits [2:0] pick the register. Reads of registers 2, 4 and 7 return vid_rdata; reads of any other video register return 0.
- R3: A read of 0x4016 returns pad1_rdata and a read of 0x4017 returns pad2_rdata. A port whose pad_present bit (bit 0 for port 1, bit 1 for port 2) is low reads as 0. Both reads, and a write to 0x4016, select the controller ports (cs bit 3).
- R4: All other accesses in 0x4000-0x401F select the audio/IO page (cs bit 2). This includes a write to 0x4017, the frame counter, and a write to 0x4015, the audio status register. Reads of this page return 0.
- R5: A write to 0x4014 raises dma_go for exactly the one cycle in which its chip select is shown.
- R6: Accesses in 0x4020-0x5FFF raise no chip select, and reads there return 0.
- R7: Addresses 0x6000-0xFFFF select the cartridge port (cs bit 4), and reads there return cart_rdata.
- R8: The cs vector is at most one-hot. It is valid only in the cycle after the access, together with bus_stb, bus_addr, bus_wdata and bus_we. In every other cycle it is 0.
- R9: Each access makes vid_tick high for the three cycles that follow it and apu_tick high for the first of those cycles.
- R10: vid_nmi high while vid_tick is high sets cpu_nmi in the next cycle. apu_irq high while apu_tick is high sets cpu_irq in the next cycle.
- R11: A write to video register 0 that sets data bit 7 while the tracked enable is 0 and vid_vblank is 1 makes cpu_nmi a one-cycle pulse in the cycle after the next access. Clearing the bit and setting it again repeats this.
- R12: After reset the cs vector, bus_stb, dma_go, vid_tick, apu_tick, cpu_nmi and cpu_irq are all 0, and the tracked NMI enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Processor access in this cycle |
| acc_we | input | 1 | Access is a write |
| acc_addr | input | 16 | Access address |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data of the registered access |
| rd_valid | output | 1 | rd_data belongs to a read |
| bus_stb | output | 1 | Registered access strobe |
| cs | output | 5 | Chip selects {cart, pads, audio/IO, video, RAM} |
| bus_addr | output | 16 | Registered address |
| bus_wdata | output | 8 | Registered write data |
| bus_we | output | 1 | Registered write flag |
| dma_go | output | 1 | Sprite DMA start pulse |
| vid_rdata | input | 8 | Video register read data |
| vid_vblank | input | 1 | Video vertical-blank flag |
| vid_nmi | input | 1 | Video NMI request |
| vid_tick | output | 1 | Video unit clock enable |
| apu_irq | input | 1 | Audio interrupt request |
| apu_tick | output | 1 | Audio unit clock enable |
| pad1_rdata | input | 8 | Controller port 1 data |
| pad2_rdata | input | 8 | Controller port 2 data |
| pad_present | input | 2 | Controller attached, per port |
| cart_rdata | input | 8 | Cartridge read data |
| cpu_nmi | output | 1 | NMI to the processor |
| cpu_irq | output | 1 | IRQ to the processor |

## Verification
Two sources drive cpu_nmi, and they can fall on neighbouring cycles: the delayed pulse armed by an enable write, and a video NMI forwarded during the tick burst. The bench arms the pulse with vertical blank set. It then holds vid_nmi high across the next access and counts cpu_nmi cycles in that access window. It expects four, which is one delayed pulse followed by three forwarded cycles. A merge that drops either source gives a different count. The same counting is also used alone, with each source on its own, and with the enable bit already set, where no pulse may appear.

// File: rtl/cpu_bus_decode.sv
`timescale 1ns/1ps
module cpu_bus_decode #(
  parameter int DW        = 8,
  parameter int RAM_AW    = 11,
  parameter int VID_TICKS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_we,
  input  logic [15:0]   acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          bus_stb,
  output logic [4:0]    cs,
  output logic [15:0]   bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_we,
  output logic          dma_go,
  input  logic [DW-1:0] vid_rdata,
  input  logic          vid_vblank,
  input  logic          vid_nmi,
  output logic          vid_tick,
  input  logic          apu_irq,
  output logic          apu_tick,
  input  logic [DW-1:0] pad1_rdata,
  input  logic [DW-1:0] pad2_rdata,
  input  logic [1:0]    pad_present,
  input  logic [DW-1:0] cart_rdata,
  output logic          cpu_nmi,
  output logic          cpu_irq
);
  localparam int RAM_DEPTH = 1 << RAM_AW;
  localparam int TW        = $clog2(VID_TICKS + 1);

  logic [DW-1:0] mem [RAM_DEPTH];
  logic [DW-1:0] ram_q;
  logic [TW-1:0] tcnt;
  logic          nmi_en, nmi_pend;

  wire in_ram  = acc_addr < 16'h2000;
  wire in_vid  = acc_addr[15:13] == 3'b001;
  wire in_io   = acc_addr[15:5] == 11'h200;
  wire is_pad  = in_io && (acc_addr[4:0] == 5'h16 || (acc_addr[4:0] == 5'h17 && !acc_we));
  wire in_cart = acc_addr >= 16'h6000;
  wire [4:0] cs_d = {in_cart, is_pad, in_io && !is_pad, in_vid, in_ram};

  wire vreg0_wr = acc_valid && acc_we && in_vid && acc_addr[2:0] == 3'd0;
  wire nmi_arm  = vreg0_wr && !nmi_en && acc_wdata[7] && vid_vblank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_stb  <= 1'b0;
      cs       <= '0;
      dma_go   <= 1'b0;
      bus_addr <= '0;
      bus_wdata <= '0;
      bus_we   <= 1'b0;
      tcnt     <= '0;
      apu_tick <= 1'b0;
      nmi_en   <= 1'b0;
      nmi_pend <= 1'b0;
      cpu_nmi  <= 1'b0;
      cpu_irq  <= 1'b0;
    end else begin
      bus_stb  <= acc_valid;
      cs       <= acc_valid ? cs_d : '0;
      dma_go   <= acc_valid && acc_we && acc_addr == 16'h4014;
      if (acc_valid) begin
        bus_addr  <= acc_addr;
        bus_wdata <= acc_wdata;
        bus_we    <= acc_we;
      end
      if (acc_valid)       tcnt <= TW'(VID_TICKS);
      else if (tcnt != '0) tcnt <= tcnt - 1'b1;
      apu_tick <= acc_valid;
      if (vreg0_wr) nmi_en <= acc_wdata[7];
      nmi_pend <= nmi_arm || (nmi_pend && !acc_valid);
      cpu_nmi  <= (vid_nmi && vid_tick) || (nmi_pend && acc_valid);
      cpu_irq  <= apu_irq && apu_tick;
    end
  end

  always_ff @(posedge clk) begin
    if (acc_valid && in_ram) begin
      if (acc_we) mem[acc_addr[RAM_AW-1:0]] <= acc_wdata;
      ram_q <= mem[acc_addr[RAM_AW-1:0]];
    end
  end

  assign vid_tick = tcnt != '0;
  assign rd_valid = bus_stb && !bus_we;

  always_comb begin
    rd_data = '0;
    if (rd_valid) begin
      if (cs[0])
        rd_data = ram_q;
      else if (cs[1])
        rd_data = (bus_addr[2:0] == 3'd2 || bus_addr[2:0] == 3'd4 || bus_addr[2:0] == 3'd7)
                  ? vid_rdata : '0;
      else if (cs[3])
        rd_data = bus_addr[0] ? (pad_present[1] ? pad2_rdata : '0)
                              : (pad_present[0] ? pad1_rdata : '0);
      else if (cs[4])
        rd_data = cart_rdata;
    end
  end
endmodule

module cpu_bus_decode_chk #(parameter int DW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          bus_stb,
  input logic [4:0]    cs,
  input logic [15:0]   bus_addr,
  input logic          bus_we,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          dma_go,
  input logic          vid_tick,
  input logic          apu_tick,
  input logic          vid_nmi,
  input logic          apu_irq,
  input logic          cpu_nmi,
  input logic          cpu_irq
);
  AST_CS_ONEHOT:    assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cs));                              // R8
  AST_CS_WITH_STB:  assert property (@(posedge clk) disable iff (!rst_n) (cs != 5'd0) |-> bus_stb);                  // R8
  AST_STB_FOLLOWS:  assert property (@(posedge clk) disable iff (!rst_n) acc_valid |=> bus_stb);                     // R8
  AST_RAM_RANGE:    assert property (@(posedge clk) disable iff (!rst_n) cs[0] |-> bus_addr < 16'h2000);             // R1
  AST_DMA_SOURCE:   assert property (@(posedge clk) disable iff (!rst_n) dma_go |-> (cs[2] && bus_we));              // R5
  AST_UNMAPPED_RD:  assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && cs == 5'd0) |-> rd_data == '0); // R6
  AST_TICK_START:   assert property (@(posedge clk) disable iff (!rst_n) bus_stb |-> (vid_tick && apu_tick));        // R9
  AST_APU_ONCE:     assert property (@(posedge clk) disable iff (!rst_n) apu_tick |-> bus_stb);                      // R9
  AST_IRQ_FWD:      assert property (@(posedge clk) disable iff (!rst_n) (apu_irq && apu_tick) |=> cpu_irq);         // R10
  AST_NMI_FWD:      assert property (@(posedge clk) disable iff (!rst_n) (vid_nmi && vid_tick) |=> cpu_nmi);         // R10
endmodule

bind cpu_bus_decode cpu_bus_decode_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .bus_stb(bus_stb), .cs(cs),
  .bus_addr(bus_addr), .bus_we(bus_we), .rd_valid(rd_valid), .rd_data(rd_data),
  .dma_go(dma_go), .vid_tick(vid_tick), .apu_tick(apu_tick), .vid_nmi(vid_nmi),
  .apu_irq(apu_irq), .cpu_nmi(cpu_nmi), .cpu_irq(cpu_irq)
);

// File: tb/cpu_bus_decode_test.sv
`timescale 1ns/1ps
module cpu_bus_decode_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_we = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [7:0]  acc_wdata = '0;
  logic [7:0]  rd_data, bus_wdata, vid_rdata, cart_rdata;
  logic        rd_valid, bus_stb, bus_we, dma_go, vid_tick, apu_tick, cpu_nmi, cpu_irq;
  logic [4:0]  cs;
  logic [15:0] bus_addr;
  logic        vid_vblank = 1'b0, vid_nmi = 1'b0, apu_irq = 1'b0;
  logic [1:0]  pad_present = 2'b01;
  logic [7:0]  pad1_rdata = 8'h41, pad2_rdata = 8'h42;

  always #2.5 clk = ~clk;

  assign vid_rdata  = 8'hA0 | {5'd0, bus_addr[2:0]};
  assign cart_rdata = bus_addr[7:0] ^ 8'h5A;

  cpu_bus_decode uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .bus_stb(bus_stb), .cs(cs), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .dma_go(dma_go), .vid_rdata(vid_rdata), .vid_vblank(vid_vblank), .vid_nmi(vid_nmi),
    .vid_tick(vid_tick), .apu_irq(apu_irq), .apu_tick(apu_tick), .pad1_rdata(pad1_rdata),
    .pad2_rdata(pad2_rdata), .pad_present(pad_present), .cart_rdata(cart_rdata),
    .cpu_nmi(cpu_nmi), .cpu_irq(cpu_irq)
  );

  typedef struct packed { logic [4:0] cs; logic [7:0] rd; logic dma; } exp_t;
  exp_t  q[$];
  string tq[$];
  int total = 0, bad = 0;
  int n_vt, n_at, n_nmi, n_irq;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic acc(input bit we, input logic [15:0] a, input logic [7:0] d,
                     input logic [4:0] ecs, input logic [7:0] erd, input bit edma, input string tag);
    exp_t e;
    @(negedge clk);
    acc_valid = 1'b1; acc_we = we; acc_addr = a; acc_wdata = d;
    e.cs = ecs; e.rd = we ? 8'h00 : erd; e.dma = edma;
    q.push_back(e); tq.push_back(tag);
    n_vt = 0; n_at = 0; n_nmi = 0; n_irq = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      acc_valid = 1'b0;
      #1;
      n_vt += int'(vid_tick); n_at += int'(apu_tick);
      n_nmi += int'(cpu_nmi); n_irq += int'(cpu_irq);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_stb) begin
        if (q.size() == 0) begin
          total++; bad++;
          $display("FAIL R8 strobe without access act=1 exp=0");
        end else begin
          exp_t e;
          string t;
          e = q.pop_front(); t = tq.pop_front();
          chk({t, " cs"}, {11'd0, cs}, {11'd0, e.cs});
          chk({t, " rd_data"}, {8'd0, rd_data}, {8'd0, e.rd});
          chk({t, " dma_go"}, {15'd0, dma_go}, {15'd0, e.dma});
        end
      end else begin
        chk("R8 cs idle", {11'd0, cs}, 16'd0);
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R12 cs", {11'd0, cs}, 16'd0);
    chk("R12 strobes", {12'd0, bus_stb, dma_go, vid_tick, apu_tick}, 16'd0);
    chk("R12 irq nmi", {14'd0, cpu_nmi, cpu_irq}, 16'd0);
    @(negedge clk); rst_n = 1'b1;

    acc(1, 16'h0005, 8'h11, 5'b00001, 8'h00, 0, "R1 ram write");
    acc(0, 16'h0805, 8'h00, 5'b00001, 8'h11, 0, "R1 ram mirror 0x0805");
    acc(0, 16'h1805, 8'h00, 5'b00001, 8'h11, 0, "R1 ram mirror 0x1805");
    acc(1, 16'h07FF, 8'hC3, 5'b00001, 8'h00, 0, "R1 ram top write");
    acc(0, 16'h1FFF, 8'h00, 5'b00001, 8'hC3, 0, "R1 ram top mirror");

    acc(1, 16'h2000, 8'h00, 5'b00010, 8'h00, 0, "R2 video ctrl write");
    acc(0, 16'h2002, 8'h00, 5'b00010, 8'hA2, 0, "R2 video reg2");
    acc(0, 16'h3FFC, 8'h00, 5'b00010, 8'hA4, 0, "R2 video reg4 mirror");
    acc(0, 16'h200F, 8'h00, 5'b00010, 8'hA7, 0, "R2 video reg7 mirror");
    acc(0, 16'h2001, 8'h00, 5'b00010, 8'h00, 0, "R2 video reg1 reads 0");

    acc(0, 16'h4016, 8'h00, 5'b01000, 8'h41, 0, "R3 pad1 read");
    acc(0, 16'h4017, 8'h00, 5'b01000, 8'h00, 0, "R3 pad2 absent");
    pad_present = 2'b11;
    acc(0, 16'h4017, 8'h00, 5'b01000, 8'h42, 0, "R3 pad2 read");
    acc(1, 16'h4016, 8'h01, 5'b01000, 8'h00, 0, "R3 pad strobe write");

    acc(1, 16'h4015, 8'h0F, 5'b00100, 8'h00, 0, "R4 audio status write");
    acc(1, 16'h4017, 8'h40, 5'b00100, 8'h00, 0, "R4 frame counter write");
    acc(0, 16'h4015, 8'h00, 5'b00100, 8'h00, 0, "R4 audio read 0");
    acc(1, 16'h4014, 8'h02, 5'b00100, 8'h00, 1, "R5 dma write");

    acc(0, 16'h5000, 8'h00, 5'b00000, 8'h00, 0, "R6 unmapped read");
    acc(1, 16'h4020, 8'h77, 5'b00000, 8'h00, 0, "R6 unmapped write");
    acc(0, 16'h8123, 8'h00, 5'b10000, 8'h79, 0, "R7 cart read");
    acc(0, 16'h6000, 8'h00, 5'b10000, 8'h5A, 0, "R7 cart low edge");
    chk("R9 vid ticks", 16'(n_vt), 16'd3);
    chk("R9 apu ticks", 16'(n_at), 16'd1);
    chk("R10 no nmi idle", 16'(n_nmi), 16'd0);

    vid_nmi = 1'b1; apu_irq = 1'b1;
    acc(0, 16'h0805, 8'h00, 5'b00001, 8'h11, 0, "R10 forward access");
    chk("R10 nmi cycles", 16'(n_nmi), 16'd3);
    chk("R10 irq cycles", 16'(n_irq), 16'd1);
    vid_nmi = 1'b0; apu_irq = 1'b0;

    vid_vblank = 1'b1;
    acc(1, 16'h2000, 8'h80, 5'b00010, 8'h00, 0, "R11 enable write");
    chk("R11 none on write", 16'(n_nmi), 16'd0);
    acc(0, 16'h0805, 8'h00, 5'b00001, 8'h11, 0, "R11 next access");
    chk("R11 delayed pulse", 16'(n_nmi), 16'd1);
    acc(1, 16'h2008, 8'h80, 5'b00010, 8'h00, 0, "R11 enable again");
    acc(0, 16'h0805, 8'h00, 5'b00001, 8'h11, 0, "R11 after no rise");
    chk("R11 no pulse already on", 16'(n_nmi), 16'd0);
    acc(1, 16'h2000, 8'h00, 5'b00010, 8'h00, 0, "R11 disable");
    acc(1, 16'h2000, 8'h80, 5'b00010, 8'h00, 0, "R11 re-enable");
    acc(0, 16'h0805, 8'h00, 5'b00001, 8'h11, 0, "R11 next access 2");
    chk("R11 repeated toggle pulse", 16'(n_nmi), 16'd1);

    acc(1, 16'h2000, 8'h00, 5'b00010, 8'h00, 0, "R11 disable 2");
    acc(1, 16'h2000, 8'h80, 5'b00010, 8'h00, 0, "R11 arm for overlap");
    vid_nmi = 1'b1;
    acc(0, 16'h0805, 8'h00, 5'b00001, 8'h11, 0, "R11 overlap access");
    chk("R11 R10 merged nmi cycles", 16'(n_nmi), 16'd4);
    vid_nmi = 1'b0;

    vid_vblank = 1'b0;
    acc(1, 16'h2000, 8'h00, 5'b00010, 8'h00, 0, "R11 disable 3");
    acc(1, 16'h2000, 8'h80, 5'b00010, 8'h00, 0, "R11 enable no vblank");
    acc(0, 16'h0805, 8'h00, 5'b00001, 8'h11, 0, "R11 next no vblank");
    chk("R11 no pulse outside vblank", 16'(n_nmi), 16'd0);

    repeat (3) @(negedge clk);
    chk("R8 queue drained", 16'(q.size()), 16'd0);
    finish_up();
  end
endmodule